// File: doc/BRIEF.md
# Prescaled Interval Timer

This peripheral counts down from a programmable reload value and flags each time the count runs out. The system clock first passes through a programmable divider; each divided tick (or, in event mode, each synchronized rising edge on an external pin) moves the counter one step down. When the counter runs out, the block raises a sticky interrupt and acts on its output pin. Depending on the control register, it then either reloads and keeps running, or stops.

Software drives the block through a four-word register port: control, reload value, current count (read only) and divider setting. The external pin has two uses. It can gate clock-driven counting, or it can be the event source in edge-counting mode.

Top module: `ptimer_top`

## Requirements
- R1: The divider setting (address 3) is a value P; in clock mode the counter advances once every P+1 clock cycles while running.
- R2: A write to the reload register (address 1) loads both the reload value and the live count. A reload value of N gives an expiry on the N-th advance, with the count readable at address 2 stepping N, N-1, … down to the expiry.
- R3: The interrupt output rises the cycle after an expiry and stays high until a control write with bit 5 set. An expiry in that same cycle wins over the clear.
- R4: With the reload bit (control bit 1) clear, an expiry leaves the count at 0 and clears the run bit (control bit 0). Counting then stops.
- R5: With control bit 1 set, an expiry reloads the count from the reload register and counting continues, giving periodic expiries.
- R6: With control bit 2 clear, the output pin is high for exactly the one cycle that follows each expiry.
- R7: With control bit 2 set, the output pin inverts in the cycle after each expiry, forming a square wave.
- R8: With control bit 3 set in clock mode, the divider and the counter hold while the synchronized external input is low.
- R9: With control bit 4 set, the counter advances once per rising edge of the external input, seen through a two-stage synchronizer; the divider and gate are ignored.
- R10: Writes to address 2 have no effect on the count.
- R11: After reset all registers read 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the selected register |
| irq | output | 1 | Sticky expiry interrupt |
| tmr_out | output | 1 | Timer output pin |
| ext_in | input | 1 | External gate / event input |

## Verification
The bench targets four boundaries. The first is the exact divider period, where an off-by-one would stretch or shrink every period by one clock. The second is the one-shot stop, where a faulty design would wrap to the reload value or leave the run bit set. The third is the interrupt hold across later idle cycles and its clear; a bad clear would drop the flag early or never. The fourth is gated and event counting, where a missed edge detector would count input levels instead of edges, or would keep counting while the gate is low. A read-only count that accepted writes would show up as a corrupted readback.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
   localparam logic [1:0] REG_CTRL   = 2'd0;
   localparam logic [1:0] REG_RELOAD = 2'd1;
   localparam logic [1:0] REG_COUNT  = 2'd2;
   localparam logic [1:0] REG_DIV    = 2'd3;
   localparam int         CTRL_W     = 5;
   localparam int         IRQ_CLR_BIT = 5;

   typedef struct packed {
      logic evt_mode;   // bit 4
      logic gate_en;    // bit 3
      logic toggle;     // bit 2
      logic auto_rl;    // bit 1
      logic run;        // bit 0
   } ctrl_t;
endpackage

// File: rtl/ptimer_sync.sv
module ptimer_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ptimer_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] pipe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-1:0], din};
   end

   assign level = pipe_q[STAGES-1];
   assign rise  = pipe_q[STAGES-1] & ~pipe_q[STAGES];

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R9
endmodule

// File: rtl/ptimer_prescale.sv
module ptimer_prescale #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [PRE_W-1:0] div,
   output logic             tick
);
   generate
      if (PRE_W < 1) begin : g_bad
         $error("ptimer_prescale: PRE_W must be positive");
      end
   endgenerate

   logic [PRE_W-1:0] cnt_q;
   logic             wrap;

   assign wrap = (cnt_q >= div);
   assign tick = en && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else if (en)       cnt_q <= wrap ? '0 : cnt_q + 1'b1;
   end

   AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0 && !clr) |=> (!tick || div == '0)); // R1
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload,
   input  logic             auto_rl,
   input  logic             toggle,
   output logic [CNT_W-1:0] count,
   output logic             expire,
   output logic             pin
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] count_q;
   logic             pin_q;

   assign expire = adv && (count_q <= ONE);
   assign count  = count_q;
   assign pin    = pin_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      count_q <= '0;
      else if (load)   count_q <= load_val;
      else if (expire) count_q <= auto_rl ? reload : '0;
      else if (adv)    count_q <= count_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      pin_q <= 1'b0;
      else if (toggle) pin_q <= expire ? ~pin_q : pin_q;
      else             pin_q <= expire;
   end

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !load) |=> $stable(count_q)); // R2
   AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && auto_rl && !load) |=> (count_q == $past(reload))); // R5
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top #(
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 16,
   parameter int PRE_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              tmr_out,
   input  logic              ext_in
);
   import ptimer_pkg::*;

   generate
      if (DATA_W < CNT_W || DATA_W < PRE_W || DATA_W <= IRQ_CLR_BIT) begin : g_bad
         $error("ptimer_top: DATA_W too narrow for the register fields");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic [PRE_W-1:0] div_q;
   logic             irq_q;
   logic             wr_ctrl, wr_reload, wr_div, clr_req;
   logic             ext_lvl, ext_rise, presc_en, ptick, adv, expire;
   logic [CNT_W-1:0] count;

   assign wr_ctrl   = wr_en && addr == REG_CTRL;
   assign wr_reload = wr_en && addr == REG_RELOAD;
   assign wr_div    = wr_en && addr == REG_DIV;
   assign clr_req   = wr_ctrl && wdata[IRQ_CLR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)                           ctrl_q <= '0;
      else if (wr_ctrl)                     ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      else if (expire && !ctrl_q.auto_rl)   ctrl_q.run <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload_q <= '0;
         div_q    <= '0;
         irq_q    <= 1'b0;
      end else begin
         if (wr_reload) reload_q <= wdata[CNT_W-1:0];
         if (wr_div)    div_q    <= wdata[PRE_W-1:0];
         if (expire)       irq_q <= 1'b1;
         else if (clr_req) irq_q <= 1'b0;
      end
   end

   ptimer_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_in), .level(ext_lvl), .rise(ext_rise));

   assign presc_en = ctrl_q.run && !ctrl_q.evt_mode && (!ctrl_q.gate_en || ext_lvl);

   ptimer_prescale #(.PRE_W(PRE_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .clr(!ctrl_q.run), .en(presc_en),
      .div(div_q), .tick(ptick));

   assign adv = ctrl_q.run && (ctrl_q.evt_mode ? ext_rise : ptick);

   ptimer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .adv(adv), .load(wr_reload),
      .load_val(wdata[CNT_W-1:0]), .reload(reload_q), .auto_rl(ctrl_q.auto_rl),
      .toggle(ctrl_q.toggle), .count(count), .expire(expire), .pin(tmr_out));

   assign irq = irq_q;

   always_comb begin
      unique case (addr)
         REG_CTRL:   rdata = DATA_W'(ctrl_q);
         REG_RELOAD: rdata = DATA_W'(reload_q);
         REG_COUNT:  rdata = DATA_W'(count);
         default:    rdata = DATA_W'(div_q);
      endcase
   end

   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> irq); // R3
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_req) |=> irq); // R3
   AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctrl_q.auto_rl && !wr_ctrl) |=> !ctrl_q.run); // R4
endmodule

// File: tb/ptimer_top_tb.sv
`timescale 1ns/1ps
module ptimer_top_tb;
   logic        clk = 0, rst_n = 0, wr_en = 0, ext_in = 0;
   logic [1:0]  addr = 0;
   logic [15:0] wdata = 0, rdata;
   logic        irq, tmr_out;
   int checks = 0, failures = 0;
   bit done = 0;
   string cur_req = "R11";

   always #4 clk = ~clk;

   ptimer_top u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq), .tmr_out(tmr_out), .ext_in(ext_in));

   // behavioural reference model
   int m_pcnt, m_count, m_reload, m_div;
   bit m_run, m_auto, m_tog, m_gate, m_evt, m_irq, m_out, s1, s2, s3;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pcnt = 0; m_count = 0; m_reload = 0; m_div = 0;
         {m_run, m_auto, m_tog, m_gate, m_evt, m_irq, m_out, s1, s2, s3} = '0;
      end else begin
         bit rise, pen, tick, adv, ex;
         int n_pcnt, n_count;
         rise = s2 && !s3;
         pen  = m_run && !m_evt && (!m_gate || s2);
         tick = pen && (m_pcnt >= m_div);
         adv  = m_run && (m_evt ? rise : tick);
         ex   = adv && (m_count <= 1);
         n_pcnt = !m_run ? 0 : (pen ? ((m_pcnt >= m_div) ? 0 : m_pcnt + 1) : m_pcnt);
         if (wr_en && addr == 1) n_count = wdata;
         else if (ex)            n_count = m_auto ? m_reload : 0;
         else if (adv)           n_count = m_count - 1;
         else                    n_count = m_count;
         m_out = m_tog ? (ex ? !m_out : m_out) : ex;
         if (ex) m_irq = 1;
         else if (wr_en && addr == 0 && wdata[5]) m_irq = 0;
         if (wr_en && addr == 0) {m_evt, m_gate, m_tog, m_auto, m_run} = wdata[4:0];
         else if (ex && !m_auto) m_run = 0;
         if (wr_en && addr == 1) m_reload = wdata;
         if (wr_en && addr == 3) m_div = wdata & 16'hff;
         m_pcnt = n_pcnt; m_count = n_count;
         s3 = s2; s2 = s1; s1 = ext_in;
      end
   end

   function automatic int m_rdata(input logic [1:0] a);
      case (a)
         2'd0: return {m_evt, m_gate, m_tog, m_auto, m_run};
         2'd1: return m_reload;
         2'd2: return m_count;
         default: return m_div;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) if (rst_n && !done) begin
      check(irq == m_irq, "R3 irq", irq, m_irq);
      check(tmr_out == m_out, cur_req, tmr_out, m_out);
      check(rdata == m_rdata(addr), "R2 rdata", rdata, m_rdata(addr));
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1; wr_en = 0; addr = addr + 1'b1;
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(posedge clk); #1; wr_en = 1; addr = a; wdata = d;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(posedge clk); #1; wr_en = 0; addr = a;
      @(negedge clk); v = rdata;
   endtask

   task automatic ext_set(input bit v);
      @(posedge clk); #1; wr_en = 0; ext_in = v;
   endtask

   task automatic wait_pulse(output int cyc);
      cyc = 0;
      @(posedge clk); #1; wr_en = 0;
      do begin @(negedge clk); cyc++; end while (!tmr_out && cyc < 500);
   endtask

   initial begin
      int v, a, b;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R11 reset state
      @(negedge clk);
      check(irq == 0, "R11 irq", irq, 0);
      check(tmr_out == 0, "R11 out", tmr_out, 0);
      for (int r = 0; r < 4; r++) begin rd(r[1:0], v); check(v == 0, "R11 reg", v, 0); end

      // R1 R2 R5 R6: divide by 3, reload 3, periodic pulses
      cur_req = "R6";
      wr(3, 2); wr(1, 3); wr(0, 16'h0003);
      idle(40);
      // R1 directed: period of P+1=5 times N=2 -> 10 cycles
      wr(3, 4); wr(1, 2); wr(0, 16'h0003);
      wait_pulse(a); wait_pulse(b);
      check(b == 10, "R1/R5 period", b, 10);
      @(negedge clk); check(tmr_out == 0, "R6 width", tmr_out, 0);

      // R3: stop without clear, flag holds; then clear
      cur_req = "R3";
      wr(0, 16'h0000); idle(6);
      check(irq == 1, "R3 hold", irq, 1);
      wr(0, 16'h0020); idle(1);
      @(negedge clk); check(irq == 0, "R3 clear", irq, 0);

      // R7: toggle mode square wave
      cur_req = "R7";
      wr(3, 0); wr(1, 2); wr(0, 16'h0007);
      idle(21);

      // R4: one-shot
      cur_req = "R4";
      wr(1, 4); wr(0, 16'h0001);
      idle(12);
      rd(0, v); check((v & 1) == 0, "R4 run cleared", v & 1, 0);
      rd(2, v); check(v == 0, "R4 count zero", v, 0);

      // R10: count is read only
      cur_req = "R10";
      wr(2, 16'h0055); idle(1);
      rd(2, v); check(v == 0, "R10 write ignored", v, 0);

      // R8: gated counting
      cur_req = "R8";
      wr(3, 1); wr(1, 3); wr(0, 16'h000B);
      ext_set(1); idle(14); ext_set(0); idle(4);
      rd(2, a); idle(10); rd(2, b);
      check(a == b, "R8 gate holds", b, a);
      ext_set(1); idle(12);

      // R9: event counting with varying pulse widths
      cur_req = "R9";
      wr(1, 3); wr(0, 16'h0013); idle(2);
      for (int k = 1; k <= 7; k++) begin
         ext_set(1); idle(k % 3 + 1); ext_set(0); idle(k % 2 + 2);
      end
      rd(2, v); check(v == m_count, "R9 event count", v, m_count);
      idle(5);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule